// File: doc/BRIEF.md
# ALU Status Flag Generator

This block derives and holds the three arithmetic status flags of an 8-bit accumulator processor: carry (C), half-carry (DC) and zero (Z). On each clock edge that ends an instruction, it looks at the instruction's operation class, the two operands and the accumulator result. When the flag-update enable is high, it updates the flags using the processor's conventions. On subtraction, the carry and half-carry flags mean "no borrow". On a rotate-through-carry, the carry flag takes the bit shifted out of the operand.

The same 3-bit field is a read/write part of a status register. Software can load it through a write strobe. When a flag-updating operation and a software write land in the same cycle, the operation wins. The other bits of the status register live elsewhere and are not touched by this block.

Top module: `sflag_unit`

## Requirements
- R1: The flag read port places C in bit 2, DC in bit 1 and Z in bit 0. The write data port uses the same bit positions.
- R2: A synchronous active-low reset clears all three flags to 0 on the next rising edge.
- R3: With `flag_en` high and `op_cls` = 2'b00 (add), C becomes the carry out of bit 7 of `opnd_a + opnd_b`.
- R4: With `flag_en` high and `op_cls` = 2'b01 (subtract `opnd_a - opnd_b`), C becomes 1 when no borrow occurs (`opnd_a >= opnd_b`, unsigned) and 0 when a borrow occurs.
- R5: With `flag_en` high and `op_cls` = 2'b10 (rotate through carry), C becomes the bit shifted out of `opnd_a`. That is bit 7 when `rot_left` is 1 and bit 0 when `rot_left` is 0. DC is left unchanged.
- R6: With `flag_en` high, DC becomes the carry from bit 3 into bit 4 on add. On subtract, DC becomes 1 when the low nibbles borrow nothing (`opnd_a[3:0] >= opnd_b[3:0]`) and 0 otherwise.
- R7: With `flag_en` high, Z becomes 1 when `result` is zero and 0 otherwise, for every operation class.
- R8: With `flag_en` high and `op_cls` = 2'b11 (logic/move), C and DC keep their values and only Z updates.
- R9: With `reg_wr` high and `flag_en` low, the flags load `reg_wdata` on the next edge.
- R10: With `flag_en` and `reg_wr` both high, the operation's result is taken for every flag bit and the write is discarded. Under a logic/move operation this means C and DC hold.
- R11: With both `flag_en` and `reg_wr` low, the flags hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; flags update on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_cls | input | 2 | Operation class: 00 add, 01 subtract, 10 rotate, 11 logic/move |
| rot_left | input | 1 | Rotate direction for class 10: 1 left, 0 right |
| opnd_a | input | 8 | First operand (rotated operand for class 10) |
| opnd_b | input | 8 | Second operand |
| result | input | 8 | Accumulator result of the instruction |
| flag_en | input | 1 | Flag-update enable for the ending instruction |
| reg_wr | input | 1 | Software write strobe for the flag field |
| reg_wdata | input | 3 | Software write data {C, DC, Z} |
| flag_rd | output | 3 | Current flags {C, DC, Z} |

## Verification
The assertions assume that `op_cls`, `rot_left`, `flag_en` and `reg_wr` are known and settled at each rising edge. They also assume that `result` is the value the accumulator datapath produced. No check compares `result` with the operands, so Z depends only on `result`.

The bench changes every input on the falling edge only and compares the registered flags one step after the edge. Its random results mostly follow the operation on the operands. About one case in six is forced to zero, so both values of Z occur often.

// File: rtl/sflag_pkg.sv
// Package: shared types and bit positions for the status flag generator.
// Assumes the flag field is three bits wide inside a larger status register.
package sflag_pkg;

    typedef enum logic [1:0] {
        OPC_ADD   = 2'b00,
        OPC_SUB   = 2'b01,
        OPC_ROT   = 2'b10,
        OPC_LOGIC = 2'b11
    } opc_e;

    localparam int FLAG_W  = 3;
    localparam int FLG_C   = 2;
    localparam int FLG_DC  = 1;
    localparam int FLG_Z   = 0;

    typedef struct packed {
        logic c;
        logic dc;
        logic z;
    } flag_t;

endpackage

// File: rtl/sflag_arith.sv
// Module: carry chain for add and subtract.
// Subtraction is formed as a + ~b + 1, so its carry outputs directly mean
// "no borrow". Assumes DATA_W is even so the nibble boundary sits at DATA_W/2.
module sflag_arith #(
    parameter int DATA_W = 8
) (
    input  logic              is_sub,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic              carry_out,
    output logic              half_carry
);
    localparam int NIB_W = DATA_W / 2;

    logic [DATA_W-1:0] b_eff;
    logic [DATA_W:0]   chain;

    // Purpose: invert the second operand for subtraction.
    always_comb b_eff = is_sub ? ~opnd_b : opnd_b;

    assign chain[0] = is_sub;

    genvar gi;
    generate
        for (gi = 0; gi < DATA_W; gi++) begin : g_bit
            // Per-bit carry: generate, or propagate the carry coming in.
            assign chain[gi+1] = (opnd_a[gi] & b_eff[gi]) |
                                 ((opnd_a[gi] ^ b_eff[gi]) & chain[gi]);
        end
    endgenerate

    assign carry_out  = chain[DATA_W];
    assign half_carry = chain[NIB_W];

endmodule

// File: rtl/sflag_rot.sv
// Module: selects the bit a rotate-through-carry shifts out of the operand.
// Assumes the left rotate pushes out the MSB and the right rotate the LSB.
module sflag_rot #(
    parameter int DATA_W = 8
) (
    input  logic              rot_left,
    input  logic [DATA_W-1:0] opnd_a,
    output logic              out_bit
);
    // Purpose: pick the end of the operand leaving the word.
    always_comb out_bit = rot_left ? opnd_a[DATA_W-1] : opnd_a[0];
endmodule

// File: rtl/sflag_zero.sv
// Module: zero detect over the accumulator result, built as an OR tree of
// pairs. Assumes DATA_W is a power of two.
module sflag_zero #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] value,
    output logic              is_zero
);
    localparam int LVLS = $clog2(DATA_W);

    logic [DATA_W-1:0] tree [0:LVLS];

    assign tree[0] = value;

    genvar lv, nd;
    generate
        for (lv = 0; lv < LVLS; lv++) begin : g_lvl
            localparam int NODES = DATA_W >> (lv + 1);
            for (nd = 0; nd < NODES; nd++) begin : g_node
                // Purpose: OR one pair from the previous level.
                assign tree[lv+1][nd] = tree[lv][2*nd] | tree[lv][2*nd+1];
            end
            assign tree[lv+1][DATA_W-1:NODES] = '0;
        end
    endgenerate

    assign is_zero = ~tree[LVLS][0];
endmodule

// File: rtl/sflag_reg.sv
// Module: the flag register with its update priority.
// The operation result wins over a software write; a logic or move updates
// only Z. Assumes the inputs are settled before the rising edge.
module sflag_reg
    import sflag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  opc_e              opc,
    input  logic              flag_en,
    input  logic              reg_wr,
    input  flag_t             wr_val,
    input  logic              arith_c,
    input  logic              arith_dc,
    input  logic              rot_c,
    input  logic              zero,
    output flag_t             flags
);
    flag_t nxt;

    // Purpose: choose the next flag value by priority and operation class.
    always_comb begin
        nxt = flags;
        if (flag_en) begin
            nxt.z = zero;
            unique case (opc)
                OPC_ADD, OPC_SUB: begin
                    nxt.c  = arith_c;
                    nxt.dc = arith_dc;
                end
                OPC_ROT:   nxt.c = rot_c;
                OPC_LOGIC: ;
                default:   ;
            endcase
        end else if (reg_wr) begin
            nxt = wr_val;
        end
    end

    // Purpose: hold the flags, cleared by the synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= nxt;
    end
endmodule

// File: rtl/sflag_unit.sv
// Module: top of the ALU status flag generator.
// It takes the operation class, the operands and the result of each
// instruction and keeps {C, DC, Z}. Assumes an 8-bit (or other even,
// power-of-two) accumulator.
module sflag_unit
    import sflag_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        op_cls,
    input  logic              rot_left,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [DATA_W-1:0] result,
    input  logic              flag_en,
    input  logic              reg_wr,
    input  logic [FLAG_W-1:0] reg_wdata,
    output logic [FLAG_W-1:0] flag_rd
);
    opc_e  opc;
    flag_t wr_val;
    flag_t flags;
    logic  arith_c, arith_dc, rot_c, zero;

    // Purpose: cast the raw ports onto the package types.
    always_comb begin
        opc       = opc_e'(op_cls);
        wr_val.c  = reg_wdata[FLG_C];
        wr_val.dc = reg_wdata[FLG_DC];
        wr_val.z  = reg_wdata[FLG_Z];
    end

    sflag_arith #(.DATA_W(DATA_W)) u_arith (
        .is_sub     (opc == OPC_SUB),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .carry_out  (arith_c),
        .half_carry (arith_dc)
    );

    sflag_rot #(.DATA_W(DATA_W)) u_rot (
        .rot_left (rot_left),
        .opnd_a   (opnd_a),
        .out_bit  (rot_c)
    );

    sflag_zero #(.DATA_W(DATA_W)) u_zero (
        .value   (result),
        .is_zero (zero)
    );

    sflag_reg u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .opc      (opc),
        .flag_en  (flag_en),
        .reg_wr   (reg_wr),
        .wr_val   (wr_val),
        .arith_c  (arith_c),
        .arith_dc (arith_dc),
        .rot_c    (rot_c),
        .zero     (zero),
        .flags    (flags)
    );

    // Purpose: drive the read port in the register's bit order.
    always_comb begin
        flag_rd[FLG_C]  = flags.c;
        flag_rd[FLG_DC] = flags.dc;
        flag_rd[FLG_Z]  = flags.z;
    end
endmodule

// File: rtl/sflag_unit_chk.sv
// Checker: temporal properties of the flag generator, seen at its ports.
// It is attached to every sflag_unit instance by the bind below.
module sflag_unit_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        op_cls,
    input logic              rot_left,
    input logic [DATA_W-1:0] opnd_a,
    input logic [DATA_W-1:0] opnd_b,
    input logic [DATA_W-1:0] result,
    input logic              flag_en,
    input logic              reg_wr,
    input logic [2:0]        reg_wdata,
    input logic [2:0]        flag_rd
);
    localparam int NIB_W = DATA_W / 2;

    logic [DATA_W:0] add_ref;
    logic [NIB_W:0]  nib_ref;
    assign add_ref = {1'b0, opnd_a} + {1'b0, opnd_b};
    assign nib_ref = {1'b0, opnd_a[NIB_W-1:0]} + {1'b0, opnd_b[NIB_W-1:0]};

    a_r2_reset_clear: assert property (@(posedge clk)
        !rst_n |=> flag_rd == 3'b000);

    a_r3_add_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_en && op_cls == 2'b00) |=> flag_rd[2] == $past(add_ref[DATA_W]));

    a_r4_sub_noborrow: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_en && op_cls == 2'b01) |=> flag_rd[2] == $past(opnd_a >= opnd_b));

    a_r6_add_half: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_en && op_cls == 2'b00) |=> flag_rd[1] == $past(nib_ref[NIB_W]));

    a_r7_zero: assert property (@(posedge clk) disable iff (!rst_n)
        flag_en |=> flag_rd[0] == $past(result == '0));

    a_r8_logic_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_en && op_cls == 2'b11) |=> $stable(flag_rd[2:1]));

    a_r9_sw_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !flag_en) |=> flag_rd == $past(reg_wdata));

    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr && !flag_en) |=> $stable(flag_rd));
endmodule

bind sflag_unit sflag_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_cls    (op_cls),
    .rot_left  (rot_left),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .result    (result),
    .flag_en   (flag_en),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .flag_rd   (flag_rd)
);

// File: tb/sflag_unit_tb.sv
module sflag_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] op_cls = 2'b11;
    logic       rot_left = 1'b0;
    logic [7:0] opnd_a = '0, opnd_b = '0, result = 8'h01;
    logic       flag_en = 1'b0, reg_wr = 1'b0;
    logic [2:0] reg_wdata = '0;
    logic [2:0] flag_rd;

    int n_run = 0, n_fail = 0;
    bit done = 0;
    logic [2:0] model = 3'b000;

    always #4 clk = ~clk;

    sflag_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_cls(op_cls), .rot_left(rot_left),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result),
        .flag_en(flag_en), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .flag_rd(flag_rd)
    );

    // Spec model: next {C, DC, Z} from the requirements.
    function automatic logic [2:0] nxt_flags(logic [1:0] op, logic rl,
            logic [7:0] a, logic [7:0] b, logic [7:0] r, logic en,
            logic wr, logic [2:0] wd, logic [2:0] cur);
        logic [2:0] f;
        logic [8:0] s;
        logic [4:0] h;
        f = cur;
        if (en) begin
            f[0] = (r == 8'h00);
            case (op)
                2'b00: begin
                    s = {1'b0, a} + {1'b0, b};
                    h = {1'b0, a[3:0]} + {1'b0, b[3:0]};
                    f[2] = s[8];
                    f[1] = h[4];
                end
                2'b01: begin
                    f[2] = (a >= b);
                    f[1] = (a[3:0] >= b[3:0]);
                end
                2'b10: f[2] = rl ? a[7] : a[0];
                default: ;
            endcase
        end else if (wr) begin
            f = wd;
        end
        return f;
    endfunction

    task automatic chk(string req, logic [2:0] act, logic [2:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: flag_rd=%b expected %b", req, act, exp);
        end
    endtask

    // Apply one cycle of inputs (called at a falling edge) and check after the edge.
    task automatic cyc(string req, logic [1:0] op, logic rl, logic [7:0] a,
            logic [7:0] b, logic [7:0] r, logic en, logic wr, logic [2:0] wd);
        op_cls = op; rot_left = rl; opnd_a = a; opnd_b = b; result = r;
        flag_en = en; reg_wr = wr; reg_wdata = wd;
        model = nxt_flags(op, rl, a, b, r, en, wr, wd, model);
        @(posedge clk); #1;
        chk(req, flag_rd, model);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; flag_en = 1'b0; reg_wr = 1'b0;
        @(posedge clk); #1;
        model = 3'b000;
        chk("R2", flag_rd, 3'b000);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: timeout, flag_rd=%b expected %b", flag_rd, model);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        @(negedge clk);
        do_reset();

        // Directed corner cases.
        cyc("R1/R3", 2'b00, 0, 8'h80, 8'h80, 8'h00, 1, 0, 3'b000); // C=1 DC=0 Z=1
        cyc("R3/R6/R7", 2'b00, 0, 8'hFF, 8'h01, 8'h00, 1, 0, 3'b000);
        cyc("R6", 2'b00, 0, 8'h08, 8'h08, 8'h10, 1, 0, 3'b000);      // DC only
        cyc("R4", 2'b01, 0, 8'h05, 8'h05, 8'h00, 1, 0, 3'b000);      // equal: no borrow
        cyc("R4/R6", 2'b01, 0, 8'h03, 8'h04, 8'hFF, 1, 0, 3'b000);   // borrow
        cyc("R6", 2'b01, 0, 8'h20, 8'h11, 8'h0F, 1, 0, 3'b000);      // nibble borrow only
        cyc("R5", 2'b10, 1, 8'h80, 8'h00, 8'h00, 1, 0, 3'b000);      // left out 1
        cyc("R5", 2'b10, 0, 8'hFE, 8'h00, 8'h7F, 1, 0, 3'b000);      // right out 0
        cyc("R9", 2'b00, 0, 8'h00, 8'h00, 8'h00, 0, 1, 3'b111);
        cyc("R8", 2'b11, 0, 8'h00, 8'h00, 8'h5A, 1, 0, 3'b000);      // C,DC stay 1
        cyc("R10", 2'b11, 0, 8'h00, 8'h00, 8'h00, 1, 1, 3'b000);     // write dropped
        cyc("R10", 2'b00, 0, 8'h01, 8'h01, 8'h02, 1, 1, 3'b111);
        cyc("R11", 2'b00, 0, 8'hFF, 8'hFF, 8'h00, 0, 0, 3'b101);
        cyc("R9/R1", 2'b00, 0, 8'h00, 8'h00, 8'h00, 0, 1, 3'b010);
        do_reset();

        // Constrained random mix.
        for (int i = 0; i < 2000; i++) begin
            logic [1:0] op;
            logic rl, en, wr;
            logic [7:0] a, b, r;
            logic [2:0] wd;
            string tag;
            op = 2'($urandom_range(0, 3));
            rl = 1'($urandom_range(0, 1));
            a  = 8'($urandom); b = 8'($urandom);
            if ($urandom_range(0, 7) == 0) b = a;
            case (op)
                2'b00: r = a + b;
                2'b01: r = a - b;
                2'b10: r = rl ? {a[6:0], 1'b0} : {1'b0, a[7:1]};
                default: r = a & b;
            endcase
            if ($urandom_range(0, 5) == 0) r = 8'h00;
            en = ($urandom_range(0, 9) < 7);
            wr = ($urandom_range(0, 3) == 0);
            wd = 3'($urandom);
            if (en && wr)      tag = "R10";
            else if (!en && wr) tag = "R9";
            else if (!en)       tag = "R11";
            else case (op)
                2'b00: tag = "R3/R6/R7";
                2'b01: tag = "R4/R6/R7";
                2'b10: tag = "R5/R7";
                default: tag = "R8/R7";
            endcase
            cyc(tag, op, rl, a, b, r, en, wr, wd);
            if (i == 1000) do_reset();
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule